// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits in front of a flash programming engine. Every write or erase request carries a byte address. The gate answers in the same cycle whether that request may go ahead. An address is refused when it falls in a locked region or lies beyond the end of the array. The uppermost rows of the array can be set aside for data storage that emulates byte-alterable memory. Requests that land there are always allowed, whatever the locks say. The size of that area comes from a 3-bit code.

The gate also holds a protection bit that shuts out external access. A dedicated command sets the bit, and only a whole-array erase clears it. A sticky error flag records every refused request and every protection command that failed. Software clears the flag with a write-one-to-clear pulse.

Top module: `flash_guard`

## Requirements
- R1: The reserved top area is sized from `eep_code`. Code 7 reserves nothing. A code c from 0 to 6 reserves 2^(6-c) rows of 256 bytes, and the area ends at byte `FLASH_BYTES-1`.
- R2: A request whose address lies inside the reserved top area is granted even when the lock bit of its region is 1.
- R3: Outside the reserved area and below `FLASH_BYTES`, the region index is `addr / (FLASH_BYTES/NUM_REGIONS)`. A request is denied when `lock_mask` bit [index] is 1 and granted when it is 0.
- R4: A request with `addr >= FLASH_BYTES` is always denied.
- R5: `req_grant` and `req_deny` depend only on the current inputs. Both are 0 while `req_valid` is 0. Exactly one of them is 1 while `req_valid` is 1.
- R6: A denied request sets `prog_err` at the next clock edge. `prog_err` then stays 1 until `prog_err_clr` is 1 at an edge. When a new error and a clear arrive at the same edge, the new error wins.
- R7: `set_sec` sets `sec_on` at the next edge. `sec_on` then stays 1 until a chip erase, and it rises for no other reason.
- R8: `chip_erase` clears `sec_on` at the next edge and takes priority over `set_sec`.
- R9: A `set_sec` that arrives together with `chip_erase` or with `req_valid` fails. It leaves `sec_on` unchanged and sets `prog_err` at the next edge.
- R10: After reset, `sec_on` and `prog_err` are 0. `ext_ok` equals `ext_req` while `sec_on` is 0, and `ext_deny` equals `ext_req` while `sec_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eep_code | input | 3 | Reserved top-area size code |
| lock_mask | input | NUM_REGIONS | Per-region lock bits, 1 = locked |
| req_valid | input | 1 | Write or erase request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_grant | output | 1 | Request allowed |
| req_deny | output | 1 | Request refused |
| set_sec | input | 1 | Set-protection command |
| chip_erase | input | 1 | Whole-array erase command, clears protection |
| sec_on | output | 1 | Protection bit |
| ext_req | input | 1 | External access request |
| ext_ok | output | 1 | External access allowed |
| ext_deny | output | 1 | External access refused |
| prog_err_clr | input | 1 | Write-one-to-clear for the error flag |
| prog_err | output | 1 | Sticky programming-error flag |

## Verification
The bench builds the gate with a 64 KiB array split into eight 8 KiB regions and an 18-bit address. With that shape the largest reserved area, 16 KiB, covers two whole regions. The smallest area, a single row, sits inside the last region. The reserved-area edge and the region edges can therefore be probed on both sides with a handful of addresses. The 18-bit address also reaches beyond the array, so out-of-range requests can be driven directly.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
   localparam int ROW_SHIFT  = 8;      // 256-byte rows
   localparam int CODE_W     = 3;
   localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;
   localparam int MAX_SPAN_SHIFT = ROW_SHIFT + 6;  // code 0: 64 rows

   typedef struct packed {
      logic in_eep;
      logic in_array;
      logic locked;
   } addr_class_t;
endpackage

// File: rtl/flash_guard_eep_span.sv
module flash_guard_eep_span
   import flash_guard_pkg::*;
#(
   parameter int FLASH_BYTES = 262144,
   parameter int ADDR_W      = 20,
   parameter bit EEP_EN      = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic [ADDR_W-1:0] addr,
   output logic              in_eep
);
   localparam logic [32:0] TOP = 33'(FLASH_BYTES);

   generate
      if (EEP_EN) begin : g_span
         logic [3:0]  shamt;
         logic [32:0] span;
         logic [32:0] base;
         logic [32:0] a_ext;
         always_comb begin
            shamt  = 4'(MAX_SPAN_SHIFT) - 4'(code);
            span   = 33'd1 << shamt;
            base   = TOP - span;
            a_ext  = 33'(addr);
            in_eep = (code != CODE_NONE) && (a_ext >= base) && (a_ext < TOP);
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{code, addr};
         assign in_eep    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/flash_guard_region_lock.sv
module flash_guard_region_lock #(
   parameter int FLASH_BYTES = 262144,
   parameter int NUM_REGIONS = 16,
   parameter int ADDR_W      = 20
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NUM_REGIONS-1:0] mask,
   output logic                   in_array,
   output logic                   locked
);
   localparam int REGION_BYTES = FLASH_BYTES / NUM_REGIONS;
   localparam int REGION_SHIFT = $clog2(REGION_BYTES);
   localparam int IDX_W        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

   logic [32:0] a_ext;
   assign a_ext    = 33'(addr);
   assign in_array = a_ext < 33'(FLASH_BYTES);

   generate
      if (NUM_REGIONS == 1) begin : g_single
         assign locked = mask[0];
      end else begin : g_multi
         logic [IDX_W-1:0]       idx;
         logic [NUM_REGIONS-1:0] hit;
         assign idx = a_ext[REGION_SHIFT +: IDX_W];
         for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_hit
            assign hit[i] = (idx == IDX_W'(i));
         end
         assign locked = |(hit & mask);
      end
   endgenerate
endmodule

// File: rtl/flash_guard_sec_reg.sv
module flash_guard_sec_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_sec,
   input  logic chip_erase,
   input  logic busy,
   output logic sec_on,
   output logic set_fail
);
   assign set_fail = set_sec & (chip_erase | busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sec_on <= 1'b0;
      else if (chip_erase)
         sec_on <= 1'b0;
      else if (set_sec && !busy)
         sec_on <= 1'b1;
   end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int FLASH_BYTES = 262144,
   parameter int NUM_REGIONS = 16,
   parameter int ADDR_W      = 20,
   parameter bit EEP_EN      = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             eep_code,
   input  logic [NUM_REGIONS-1:0] lock_mask,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   output logic                   req_grant,
   output logic                   req_deny,
   input  logic                   set_sec,
   input  logic                   chip_erase,
   output logic                   sec_on,
   input  logic                   ext_req,
   output logic                   ext_ok,
   output logic                   ext_deny,
   input  logic                   prog_err_clr,
   output logic                   prog_err
);
   generate
      if (ADDR_W > 32 || (64'd1 << ADDR_W) < 64'(FLASH_BYTES)) begin : g_bad_addr
         $error("flash_guard: ADDR_W cannot span FLASH_BYTES or exceeds 32");
      end
      if ((FLASH_BYTES & (FLASH_BYTES - 1)) != 0 || FLASH_BYTES < (1 << MAX_SPAN_SHIFT)) begin : g_bad_size
         $error("flash_guard: FLASH_BYTES must be a power of two of at least 16 KiB");
      end
      if (NUM_REGIONS < 1 || (NUM_REGIONS & (NUM_REGIONS - 1)) != 0) begin : g_bad_regions
         $error("flash_guard: NUM_REGIONS must be a power of two");
      end
   endgenerate

   addr_class_t cls;
   logic        allowed;
   logic        set_fail;
   logic        err_evt;

   flash_guard_eep_span #(
      .FLASH_BYTES(FLASH_BYTES), .ADDR_W(ADDR_W), .EEP_EN(EEP_EN)
   ) u_span (
      .code(eep_code), .addr(req_addr), .in_eep(cls.in_eep)
   );

   flash_guard_region_lock #(
      .FLASH_BYTES(FLASH_BYTES), .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)
   ) u_lock (
      .addr(req_addr), .mask(lock_mask), .in_array(cls.in_array), .locked(cls.locked)
   );

   flash_guard_sec_reg u_sec (
      .clk(clk), .rst_n(rst_n), .set_sec(set_sec), .chip_erase(chip_erase),
      .busy(req_valid), .sec_on(sec_on), .set_fail(set_fail)
   );

   assign allowed   = cls.in_array & (cls.in_eep | ~cls.locked);
   assign req_grant = req_valid & allowed;
   assign req_deny  = req_valid & ~allowed;

   assign ext_ok    = ext_req & ~sec_on;
   assign ext_deny  = ext_req &  sec_on;

   assign err_evt   = req_deny | set_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prog_err <= 1'b0;
      else if (err_evt)
         prog_err <= 1'b1;
      else if (prog_err_clr)
         prog_err <= 1'b0;
   end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
   parameter int FLASH_BYTES = 262144,
   parameter int ADDR_W      = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_grant,
   input logic              req_deny,
   input logic              set_sec,
   input logic              chip_erase,
   input logic              sec_on,
   input logic              ext_req,
   input logic              ext_ok,
   input logic              ext_deny,
   input logic              prog_err_clr,
   input logic              prog_err
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(req_grant || req_deny));                             // R5
   AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $countones({req_grant, req_deny}) == 1);                 // R5
   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && 33'(req_addr) >= 33'(FLASH_BYTES)) |-> req_deny);        // R4
   AST_ERR_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      req_deny |=> prog_err);                                                // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_err && !prog_err_clr) |=> prog_err);                             // R6
   AST_SEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sec && !chip_erase && !req_valid) |=> sec_on);                    // R7
   AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_on && !chip_erase) |=> sec_on);                                   // R7
   AST_SEC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_on) |-> $past(set_sec));                                     // R7
   AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase |=> !sec_on);                                               // R8
   AST_SET_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sec && (chip_erase || req_valid)) |=> prog_err);                  // R9
   AST_EXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      sec_on |-> !ext_ok);                                                   // R10
   AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_on && ext_req) |-> (ext_ok && !ext_deny));                       // R10
endmodule

bind flash_guard flash_guard_chk #(.FLASH_BYTES(FLASH_BYTES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_grant(req_grant), .req_deny(req_deny), .set_sec(set_sec),
   .chip_erase(chip_erase), .sec_on(sec_on), .ext_req(ext_req), .ext_ok(ext_ok),
   .ext_deny(ext_deny), .prog_err_clr(prog_err_clr), .prog_err(prog_err)
);

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;
   localparam int FB = 65536;
   localparam int NR = 8;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    eep_code = 3'd7;
   logic [NR-1:0] lock_mask = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_grant, req_deny;
   logic          set_sec = 1'b0, chip_erase = 1'b0;
   logic          sec_on;
   logic          ext_req = 1'b0;
   logic          ext_ok, ext_deny;
   logic          prog_err_clr = 1'b0;
   logic          prog_err;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   flash_guard #(.FLASH_BYTES(FB), .NUM_REGIONS(NR), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .eep_code(eep_code), .lock_mask(lock_mask),
      .req_valid(req_valid), .req_addr(req_addr), .req_grant(req_grant),
      .req_deny(req_deny), .set_sec(set_sec), .chip_erase(chip_erase),
      .sec_on(sec_on), .ext_req(ext_req), .ext_ok(ext_ok), .ext_deny(ext_deny),
      .prog_err_clr(prog_err_clr), .prog_err(prog_err)
   );

   // {code, mask, addr, expect_grant}; 8 KiB regions, 64 KiB array
   localparam int NV = 16;
   localparam logic [29:0] VT [NV] = '{
      {3'd7, 8'h00, 18'h00100, 1'b1},   // unlocked region 0
      {3'd7, 8'h01, 18'h00100, 1'b0},   // region 0 locked
      {3'd7, 8'h80, 18'h0FFF0, 1'b0},   // no reserved area, region 7 locked
      {3'd0, 8'h80, 18'h0FFF0, 1'b1},   // inside 16 KiB area
      {3'd0, 8'hC0, 18'h0C000, 1'b1},   // lowest byte of 16 KiB area
      {3'd0, 8'h20, 18'h0BFFF, 1'b0},   // just below area, region 5 locked
      {3'd6, 8'h80, 18'h0FF00, 1'b1},   // single row area
      {3'd6, 8'h80, 18'h0FEFF, 1'b0},   // one byte below single row
      {3'd3, 8'h80, 18'h0F800, 1'b1},   // 8 rows, base
      {3'd3, 8'h80, 18'h0F7FF, 1'b0},   // 8 rows, below base
      {3'd1, 8'h80, 18'h0E000, 1'b1},   // 32 rows, base
      {3'd1, 8'h40, 18'h0DFFF, 1'b0},   // 32 rows, below base, region 6 locked
      {3'd5, 8'h80, 18'h0FE00, 1'b1},   // 2 rows, base
      {3'd7, 8'hFF, 18'h10000, 1'b0},   // beyond array
      {3'd0, 8'h00, 18'h3FFFF, 1'b0},   // beyond array, unlocked
      {3'd2, 8'h7F, 18'h0FFFF, 1'b1}    // last byte, 16 rows, region 7 open
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      ext_req = 1'b1;
      #1;
      chk("R10 reset sec_on", 32'(sec_on), 0);
      chk("R10 reset prog_err", 32'(prog_err), 0);
      rst_n = 1'b1;
      tick();
      chk("R10 ext_ok unprotected", 32'(ext_ok), 1);
      chk("R5 idle no decision", 32'({req_grant, req_deny}), 0);
      ext_req = 1'b0;

      // table walk: decision, then error flag
      for (int i = 0; i < NV; i++) begin
         eep_code  = VT[i][29:27];
         lock_mask = VT[i][26:19];
         req_addr  = VT[i][18:1];
         req_valid = 1'b1;
         #1;
         chk($sformatf("R1/R2/R3/R4/R5 vec %0d grant", i), 32'(req_grant), 32'(VT[i][0]));
         chk($sformatf("R5 vec %0d deny", i), 32'(req_deny), 32'(!VT[i][0]));
         tick();
         req_valid = 1'b0;
         #1;
         chk($sformatf("R6 vec %0d prog_err", i), 32'(prog_err), 32'(!VT[i][0]));
         prog_err_clr = 1'b1;
         tick();
         prog_err_clr = 1'b0;
      end

      // R6: sticky, set beats clear
      lock_mask = 8'h01; req_addr = '0; eep_code = 3'd7; req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
      repeat (3) tick();
      chk("R6 sticky hold", 32'(prog_err), 1);
      req_valid = 1'b1; prog_err_clr = 1'b1;
      tick();
      req_valid = 1'b0;
      chk("R6 set wins over clear", 32'(prog_err), 1);
      tick();
      prog_err_clr = 1'b0;
      chk("R6 cleared", 32'(prog_err), 0);

      // R7: set protection
      set_sec = 1'b1;
      tick();
      set_sec = 1'b0;
      chk("R7 sec set", 32'(sec_on), 1);
      chk("R7 no error on good set", 32'(prog_err), 0);
      repeat (3) tick();
      chk("R7 sec held", 32'(sec_on), 1);
      ext_req = 1'b1;
      #1;
      chk("R10 ext denied", 32'({ext_ok, ext_deny}), 1);
      ext_req = 1'b0;

      // R8: erase wins over set
      chip_erase = 1'b1; set_sec = 1'b1;
      tick();
      chip_erase = 1'b0; set_sec = 1'b0;
      chk("R8 erase clears", 32'(sec_on), 0);
      chk("R9 set with erase errors", 32'(prog_err), 1);
      prog_err_clr = 1'b1;
      tick();
      prog_err_clr = 1'b0;

      // R9: set during a granted request fails
      lock_mask = '0; req_addr = 18'h00200; req_valid = 1'b1; set_sec = 1'b1;
      tick();
      req_valid = 1'b0; set_sec = 1'b0;
      chk("R9 set while busy leaves sec", 32'(sec_on), 0);
      chk("R9 set while busy errors", 32'(prog_err), 1);
      prog_err_clr = 1'b1;
      tick();
      prog_err_clr = 1'b0;

      // R8: plain erase after a set
      set_sec = 1'b1;
      tick();
      set_sec = 1'b0;
      chip_erase = 1'b1;
      tick();
      chip_erase = 1'b0;
      chk("R8 erase alone clears", 32'(sec_on), 0);
      ext_req = 1'b1;
      #1;
      chk("R10 ext allowed again", 32'({ext_ok, ext_deny}), 2);
      ext_req = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule